// File: doc/BRIEF.md
# Two-Lane Shift-Mask Interpolator

This block is a register-mapped arithmetic helper for address generation, fixed-point stepping, linear blending and range limiting. It holds two 32-bit accumulators, one control word per lane and three 32-bit base registers. Each lane picks an accumulator, shifts it right, keeps a programmable bit window, optionally sign-extends the window and adds a base. A third result adds the last base to both lane windows.

Software reads any of the three results in one of two ways. A peek read has no side effect. A pop read also writes each lane's result back into an accumulator, so a long series of steps costs one bus read per step. Further features are a packed write that loads two bases at once, an add-into-accumulator write, address-space force bits, a blend mode that interpolates between two bases, and a clamp mode selected by a parameter.

Top module: `interp_core`

## Requirements
- R1: After reset all accumulators and bases read 0 and both control words read 0x0000_7C00 (full window 0..31). Word addresses: 0/1 accumulator 0/1, 2/3/4 base 0/1/2, 5/6/7 peek lane0/lane1/full, 8/9/10 pop lane0/lane1/full, 11/12 control lane0/lane1, 13/14 raw port lane0/lane1, 15 packed base pair.
- R2: A lane's window value is (source >> shift) with only bits mask_lo..mask_hi kept. Control fields: shift [4:0], mask_lo [9:5], mask_hi [14:10].
- R3: When the lane's signed flag (control bit 15) is set, bit mask_hi of the window value fills all bits above it.
- R4: With no mode set, lane N's result is base N plus its window value, and the full result is base 2 plus both window values.
- R5: The cross-input flag (control bit 16) makes a lane take the other lane's accumulator as its source. The raw path uses this same selected source.
- R6: The raw flag (control bit 18) makes a lane's result base N plus the unshifted source. The full result still uses the window value.
- R7: A pop read returns its result and, on that clock edge, loads each accumulator with its own lane result, or with the other lane's result when the cross-result flag (control bit 17) is set. A peek read leaves every accumulator unchanged.
- R8: The two force bits (control bits 20:19) are ORed into bits 29:28 of that lane's peek and pop read data. Accumulator write-back uses the unforced result.
- R9: A write to the packed pair address loads base 0 from data bits 15:0 and base 1 from bits 31:16. Each half is sign-extended when its lane's signed flag is set, and zero-extended otherwise.
- R10: A write to a lane's raw port adds the data to that lane's accumulator. A read of the raw port returns the lane's window value with no base added.
- R11: Blend mode (lane 0 control bit 21) makes lane 1's result base0 + ((base1 - base0) * a) / 256, with a equal to window1[7:0]. The arithmetic is signed when lane 1's signed flag is set and unsigned when it is clear. Lane 0's result becomes a with no base, and the full result drops the lane 1 term. Bits 21 and 22 of lane 1's control always read 0.
- R12: With CLAMP_EN=1, clamp mode (lane 0 control bit 22) makes lane 0's result its window value limited to the range [base0, base1]. The comparisons are signed when lane 0's signed flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; a pop has its side effect only when this is set |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The bench builds the block with CLAMP_EN=1. This brings the lane 0 range-limit path and its control bit into reach, alongside blend mode. With the default 32-bit width, the window sweep reaches shift 31, a window that does not start at bit 0, and sign fill from a mid-word top bit. At this width the force bits also land on 29:28, just under the word's top two bits.

// File: rtl/interp_pkg.sv
package interp_pkg;

   localparam int SHW = 5;

   typedef struct packed {
      logic [8:0] rsvd;
      logic       clamp;
      logic       blend;
      logic [1:0] force_bits;
      logic       add_raw;
      logic       cross_res;
      logic       cross_in;
      logic       sgn;
      logic [4:0] mhi;
      logic [4:0] mlo;
      logic [4:0] shift;
   } lane_ctrl_t;

   typedef enum logic [3:0] {
      A_ACC0  = 4'd0,  A_ACC1  = 4'd1,
      A_BASE0 = 4'd2,  A_BASE1 = 4'd3,  A_BASE2 = 4'd4,
      A_PEEK0 = 4'd5,  A_PEEK1 = 4'd6,  A_PEEKF = 4'd7,
      A_POP0  = 4'd8,  A_POP1  = 4'd9,  A_POPF  = 4'd10,
      A_CTRL0 = 4'd11, A_CTRL1 = 4'd12,
      A_RAW0  = 4'd13, A_RAW1  = 4'd14, A_PAIR  = 4'd15
   } addr_t;

   localparam logic [31:0] CTRL_RST   = 32'h0000_7C00;
   localparam logic [31:0] CTRL_BASIC = 32'h001F_FFFF;
   localparam logic [31:0] CTRL_BLEND = 32'h0020_0000;
   localparam logic [31:0] CTRL_CLAMP = 32'h0040_0000;

endpackage

// File: rtl/interp_lane.sv
module interp_lane #(
   parameter int DATA_W = 32,
   parameter int SHW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src,
   input  logic [SHW-1:0]    shift,
   input  logic [SHW-1:0]    mlo,
   input  logic [SHW-1:0]    mhi,
   input  logic              sgn,
   output logic [DATA_W-1:0] sm
);
   localparam logic [SHW-1:0] TOP = SHW'(DATA_W - 1);

   logic [DATA_W-1:0] shifted, hi_keep, lo_keep, kept;

   always_comb begin
      shifted = src >> shift;
      hi_keep = {DATA_W{1'b1}} >> (TOP - mhi);
      lo_keep = {DATA_W{1'b1}} << mlo;
      kept    = shifted & hi_keep & lo_keep;
      sm      = (sgn && kept[mhi]) ? (kept | ~hi_keep) : kept;
   end

   // R2: nothing survives below the window
   p_mask_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mlo <= mhi) |-> ((sm << (DATA_W - int'(mlo))) == '0));

   // R3: top bit of the result mirrors the window's top bit when signed
   p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sgn && (mlo <= mhi)) |-> (sm[DATA_W-1] == sm[mhi]));
endmodule

// File: rtl/interp_blend.sv
module interp_blend #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   input  logic [7:0]        alpha,
   input  logic              sgn,
   output logic [DATA_W-1:0] out
);
   localparam int PW = DATA_W + 10;

   logic signed [DATA_W:0] diff;
   logic signed [PW-1:0]   prod;

   always_comb begin
      diff = $signed({sgn & hi[DATA_W-1], hi}) - $signed({sgn & lo[DATA_W-1], lo});
      prod = PW'(diff) * PW'($signed({1'b0, alpha}));
      out  = lo + DATA_W'(prod >>> 8);
   end

   // R11: unsigned interpolation stays inside the span of the two bases
   p_blend_span_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!sgn && lo <= hi) |-> (out >= lo && out <= hi));
endmodule

// File: rtl/interp_clamp.sv
module interp_clamp #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] val,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   input  logic              sgn,
   output logic [DATA_W-1:0] out
);
   logic below, above;

   always_comb begin
      below = sgn ? ($signed(val) < $signed(lo)) : (val < lo);
      above = sgn ? ($signed(val) > $signed(hi)) : (val > hi);
      out   = below ? lo : (above ? hi : val);
   end

   // R12: the limited value lies between the bounds when they are ordered
   p_clamp_bounds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!sgn && lo <= hi) |-> (out >= lo && out <= hi));
   p_clamp_sbounds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sgn && $signed(lo) <= $signed(hi)) |->
         ($signed(out) >= $signed(lo) && $signed(out) <= $signed(hi)));
endmodule

// File: rtl/interp_core.sv
module interp_core
   import interp_pkg::*;
#(
   parameter int   DATA_W   = 32,
   parameter bit   CLAMP_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int NL   = 2;
   localparam int NB   = 3;
   localparam int HALF = DATA_W / 2;
   localparam logic [31:0] MASK1 = CTRL_BASIC;
   localparam logic [31:0] MASK0 = CTRL_BASIC | CTRL_BLEND | (CLAMP_EN ? CTRL_CLAMP : 32'h0);

   if (DATA_W != (1 << SHW)) begin : g_bad_width
      $error("interp_core: DATA_W must equal 2**SHW");
   end

   addr_t             a;
   logic [DATA_W-1:0] acc_q  [NL];
   logic [DATA_W-1:0] base_q [NB];
   lane_ctrl_t        ctrl_q [NL];
   logic [DATA_W-1:0] src [NL];
   logic [DATA_W-1:0] sm  [NL];
   logic [DATA_W-1:0] res [NL];
   logic [DATA_W-1:0] view [NL];
   logic [DATA_W-1:0] full, blend_val, clamp_val;
   logic              clamp_on, blend_on, pop_hit;

   assign a = addr_t'(bus_addr);

   for (genvar l = 0; l < NL; l++) begin : g_lane
      assign src[l] = ctrl_q[l].cross_in ? acc_q[NL-1-l] : acc_q[l];
      interp_lane #(.DATA_W(DATA_W), .SHW(SHW)) u_lane (
         .clk(clk), .rst_n(rst_n), .src(src[l]),
         .shift(ctrl_q[l].shift), .mlo(ctrl_q[l].mlo), .mhi(ctrl_q[l].mhi),
         .sgn(ctrl_q[l].sgn), .sm(sm[l]));
      assign view[l] = res[l] | {{(DATA_W-30){1'b0}}, ctrl_q[l].force_bits, 28'b0};
   end

   interp_blend #(.DATA_W(DATA_W)) u_blend (
      .clk(clk), .rst_n(rst_n), .lo(base_q[0]), .hi(base_q[1]),
      .alpha(sm[1][7:0]), .sgn(ctrl_q[1].sgn), .out(blend_val));

   if (CLAMP_EN) begin : g_clamp
      interp_clamp #(.DATA_W(DATA_W)) u_clamp (
         .clk(clk), .rst_n(rst_n), .val(sm[0]), .lo(base_q[0]), .hi(base_q[1]),
         .sgn(ctrl_q[0].sgn), .out(clamp_val));
      assign clamp_on = ctrl_q[0].clamp;
   end else begin : g_no_clamp
      assign clamp_val = '0;
      assign clamp_on  = 1'b0;
   end

   assign blend_on = ctrl_q[0].blend;

   always_comb begin
      if (blend_on)      res[0] = {{(DATA_W-8){1'b0}}, sm[1][7:0]};
      else if (clamp_on) res[0] = clamp_val;
      else               res[0] = base_q[0] + (ctrl_q[0].add_raw ? src[0] : sm[0]);
      if (blend_on)      res[1] = blend_val;
      else               res[1] = base_q[1] + (ctrl_q[1].add_raw ? src[1] : sm[1]);
      full = base_q[2] + sm[0] + (blend_on ? '0 : sm[1]);
   end

   assign pop_hit = bus_re && (a == A_POP0 || a == A_POP1 || a == A_POPF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NL; i++) begin
            acc_q[i]  <= '0;
            ctrl_q[i] <= lane_ctrl_t'(CTRL_RST);
         end
         for (int i = 0; i < NB; i++) base_q[i] <= '0;
      end else begin
         if (pop_hit) begin
            acc_q[0] <= ctrl_q[0].cross_res ? res[1] : res[0];
            acc_q[1] <= ctrl_q[1].cross_res ? res[0] : res[1];
         end
         if (bus_we) begin
            case (a)
               A_ACC0:  acc_q[0]  <= bus_wdata;
               A_ACC1:  acc_q[1]  <= bus_wdata;
               A_RAW0:  acc_q[0]  <= acc_q[0] + bus_wdata;
               A_RAW1:  acc_q[1]  <= acc_q[1] + bus_wdata;
               A_BASE0: base_q[0] <= bus_wdata;
               A_BASE1: base_q[1] <= bus_wdata;
               A_BASE2: base_q[2] <= bus_wdata;
               A_CTRL0: ctrl_q[0] <= lane_ctrl_t'(bus_wdata & MASK0);
               A_CTRL1: ctrl_q[1] <= lane_ctrl_t'(bus_wdata & MASK1);
               A_PAIR: begin
                  base_q[0] <= {{HALF{ctrl_q[0].sgn & bus_wdata[HALF-1]}}, bus_wdata[HALF-1:0]};
                  base_q[1] <= {{HALF{ctrl_q[1].sgn & bus_wdata[DATA_W-1]}}, bus_wdata[DATA_W-1:HALF]};
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (a)
         A_ACC0:          bus_rdata = acc_q[0];
         A_ACC1:          bus_rdata = acc_q[1];
         A_BASE0:         bus_rdata = base_q[0];
         A_BASE1:         bus_rdata = base_q[1];
         A_BASE2:         bus_rdata = base_q[2];
         A_PEEK0, A_POP0: bus_rdata = view[0];
         A_PEEK1, A_POP1: bus_rdata = view[1];
         A_PEEKF, A_POPF: bus_rdata = full;
         A_CTRL0:         bus_rdata = ctrl_q[0];
         A_CTRL1:         bus_rdata = ctrl_q[1];
         A_RAW0:          bus_rdata = sm[0];
         A_RAW1:          bus_rdata = sm[1];
         default:         bus_rdata = '0;
      endcase
   end

   // R7: peek reads leave both accumulators untouched
   p_peek_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we && (a == A_PEEK0 || a == A_PEEK1 || a == A_PEEKF))
      |=> ($stable(acc_q[0]) && $stable(acc_q[1])));

   // R7: an unforced, uncrossed lane-0 pop reloads accumulator 0 with the value read
   p_pop_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we && a == A_POP0 && ctrl_q[0].force_bits == 2'b00 && !ctrl_q[0].cross_res)
      |=> (acc_q[0] == $past(bus_rdata)));

   // R10: raw-port write accumulates
   p_raw_add_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && a == A_RAW0) |=> (acc_q[0] == $past(acc_q[0]) + $past(bus_wdata)));

   // R9: packed pair write places each half in its base
   p_pair_halves_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && a == A_PAIR) |=>
         (base_q[0][HALF-1:0] == $past(bus_wdata[HALF-1:0]) &&
          base_q[1][HALF-1:0] == $past(bus_wdata[DATA_W-1:HALF])));
endmodule

// File: tb/test_interp_core.sv
module test_interp_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   interp_core #(.DATA_W(32), .CLAMP_EN(1'b1)) i_interp_core (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata));

   // {ctrl0, acc0, base0, expected peek0}
   localparam logic [127:0] VEC [7] = '{
      {32'h0000_7C00, 32'h1234_5678, 32'h0000_0000, 32'h1234_5678},
      {32'h0000_1C04, 32'h1234_5678, 32'h0000_0100, 32'h0000_0167},
      {32'h0000_2C88, 32'hABCD_EF12, 32'h0000_0000, 32'h0000_0DE0},
      {32'h0000_9C00, 32'h0000_0080, 32'h0000_0010, 32'hFFFF_FF90},
      {32'h0000_9C00, 32'h0000_017F, 32'h0000_0001, 32'h0000_0080},
      {32'h0000_9C80, 32'h0000_00F5, 32'h0000_0000, 32'hFFFF_FFF0},
      {32'h0000_7C1F, 32'h8000_0000, 32'h0000_0005, 32'h0000_0006}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] adr, input logic [31:0] d);
      @(negedge clk);
      bus_addr = adr; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] adr, output logic [31:0] d);
      @(negedge clk);
      bus_addr = adr; bus_we = 1'b0; bus_re = 1'b1;
      #2 d = bus_rdata;
      @(posedge clk); #1;
      bus_re = 1'b0;
   endtask

   task automatic expect_rd(input string tag, input logic [3:0] adr, input logic [31:0] exp);
      logic [31:0] v;
      rd(adr, v);
      chk(tag, v, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      expect_rd("R1 ctrl0", 4'd11, 32'h0000_7C00);
      expect_rd("R1 ctrl1", 4'd12, 32'h0000_7C00);
      expect_rd("R1 acc0", 4'd0, 32'h0);
      expect_rd("R1 peek0", 4'd5, 32'h0);
      expect_rd("R1 full", 4'd7, 32'h0);

      // R2/R3 window sweep
      for (int i = 0; i < 7; i++) begin
         wr(4'd11, VEC[i][127:96]);
         wr(4'd0,  VEC[i][95:64]);
         wr(4'd2,  VEC[i][63:32]);
         expect_rd($sformatf("R2/R3 vector %0d", i), 4'd5, VEC[i][31:0]);
      end

      // R4 plain sums
      wr(4'd11, 32'h0000_7C00); wr(4'd12, 32'h0000_7C00);
      wr(4'd0, 32'd10); wr(4'd1, 32'd20);
      wr(4'd2, 32'd1); wr(4'd3, 32'd2); wr(4'd4, 32'd1000);
      expect_rd("R4 peek0", 4'd5, 32'd11);
      expect_rd("R4 peek1", 4'd6, 32'd22);
      expect_rd("R4 full", 4'd7, 32'd1030);

      // R5 cross input, also through raw path
      wr(4'd12, 32'h0001_7C00);
      expect_rd("R5 peek1 cross", 4'd6, 32'd12);
      expect_rd("R5 full cross", 4'd7, 32'd1020);
      wr(4'd12, 32'h0005_7C01);
      expect_rd("R5 peek1 cross+raw", 4'd6, 32'd12);
      expect_rd("R6 full keeps window", 4'd7, 32'd1015);

      // R6 raw bypass on lane 0
      wr(4'd12, 32'h0000_7C00); wr(4'd11, 32'h0004_7C02);
      expect_rd("R6 peek0 raw", 4'd5, 32'd11);
      expect_rd("R6 full", 4'd7, 32'd1022);

      // R10 raw port
      wr(4'd13, 32'd5);
      expect_rd("R10 acc0 after add", 4'd0, 32'd15);
      expect_rd("R10 raw0 read", 4'd13, 32'd3);
      expect_rd("R10 raw1 read", 4'd14, 32'd20);

      // R8 force bits and R7 pop
      wr(4'd11, 32'h001C_7C02);
      expect_rd("R8 peek0 forced", 4'd5, 32'h3000_0010);
      expect_rd("R8 full unforced", 4'd7, 32'd1023);
      expect_rd("R8 pop0 forced", 4'd8, 32'h3000_0010);
      expect_rd("R8 acc0 unforced writeback", 4'd0, 32'd16);
      expect_rd("R7 acc1 writeback", 4'd1, 32'd22);
      expect_rd("R7 peek1", 4'd6, 32'd24);
      expect_rd("R7 acc1 after peek", 4'd1, 32'd22);
      expect_rd("R7 acc0 after peek", 4'd0, 32'd16);

      // R7 cross result via full pop
      wr(4'd11, 32'h0002_7C00); wr(4'd12, 32'h0000_7C00);
      expect_rd("R7 popF value", 4'd10, 32'd1038);
      expect_rd("R7 acc0 cross result", 4'd0, 32'd24);
      expect_rd("R7 acc1 own result", 4'd1, 32'd24);

      // R9 packed pair
      wr(4'd11, 32'h0000_FC00);
      wr(4'd15, 32'h8001_FFFE);
      expect_rd("R9 base0 signed", 4'd2, 32'hFFFF_FFFE);
      expect_rd("R9 base1 unsigned", 4'd3, 32'h0000_8001);
      wr(4'd11, 32'h0000_7C00); wr(4'd12, 32'h0000_FC00);
      wr(4'd15, 32'h8001_FFFE);
      expect_rd("R9 base0 unsigned", 4'd2, 32'h0000_FFFE);
      expect_rd("R9 base1 signed", 4'd3, 32'hFFFF_8001);

      // R11 blend
      wr(4'd12, 32'h0000_7C00); wr(4'd11, 32'h0020_7C00);
      wr(4'd1, 32'd128); wr(4'd0, 32'd7);
      wr(4'd2, 32'd100); wr(4'd3, 32'd300);
      expect_rd("R11 peek1 half", 4'd6, 32'd200);
      expect_rd("R11 peek0 alpha", 4'd5, 32'h80);
      expect_rd("R11 full", 4'd7, 32'd1007);
      wr(4'd12, 32'h0000_FC00); wr(4'd1, 32'd64);
      wr(4'd2, 32'hFFFF_FF00); wr(4'd3, 32'h0000_0100);
      expect_rd("R11 signed blend", 4'd6, 32'hFFFF_FF80);
      wr(4'd12, 32'h0000_7C00);
      expect_rd("R11 unsigned blend", 4'd6, 32'hBFFF_FF80);
      wr(4'd1, 32'd0);
      expect_rd("R11 alpha zero", 4'd6, 32'hFFFF_FF00);
      wr(4'd12, 32'h0060_7C00);
      expect_rd("R11 lane1 mode bits read 0", 4'd12, 32'h0000_7C00);

      // R12 clamp
      wr(4'd11, 32'h0040_7C00);
      expect_rd("R12 ctrl0 clamp bit", 4'd11, 32'h0040_7C00);
      wr(4'd2, 32'd10); wr(4'd3, 32'd50);
      wr(4'd0, 32'd5);
      expect_rd("R12 below", 4'd5, 32'd10);
      wr(4'd0, 32'd30);
      expect_rd("R12 inside", 4'd5, 32'd30);
      wr(4'd0, 32'd99);
      expect_rd("R12 above", 4'd5, 32'd50);
      wr(4'd11, 32'h0040_FC00);
      wr(4'd2, 32'hFFFF_FFF6); wr(4'd3, 32'd20);
      wr(4'd0, 32'hFFFF_FFF0);
      expect_rd("R12 signed below", 4'd5, 32'hFFFF_FFF6);
      wr(4'd0, 32'd25);
      expect_rd("R12 signed above", 4'd5, 32'd20);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule